// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a byte stream. Software builds a chain of four-word descriptors. Each descriptor holds a flags word, the byte address of a frame buffer, a status word whose low half gives the frame length, and the address of the next descriptor. Software marks a descriptor as owned by hardware, then enables transmission and issues a poll pulse.

The engine fetches each descriptor over a word-wide memory master port. It reads the buffer as little-endian words and sends the frame bytes on a valid/ready byte port, with a last flag on the final byte. It then writes the completion status back and returns the descriptor to software by clearing the owner bit. After that it follows the next pointer.

The engine stops at the first descriptor that software still owns, and it stops on any error response from memory. In both cases it leaves its current-descriptor pointer on the descriptor it stopped at. A later poll resumes from that descriptor. One-cycle status pulses tell the register block about each event.

Top module: `txring_dma`

## Requirements
- R1: After reset, `tx_valid` and `mem_req` are low and `cur_desc` holds all ones, which marks the pointer as invalid.
- R2: A fetch starts only on a `poll` pulse while `tx_en` is high. A poll while `tx_en` is low produces no memory request.
- R3: When `cur_desc` is all ones at a poll, the first read goes to `list_base`. A descriptor at address D has four words: flags at D+0, buffer byte address at D+4, status/length at D+8 and next-descriptor address at D+12.
- R4: The frame length is bits 15:0 of the status/length word. Bytes leave in ascending address order. Byte lane k of a memory word is bits 8k+7:8k, and the buffer may start on any byte lane. `tx_last` is high on the final byte only.
- R5: After a frame, the engine first writes the status/length word with bit 19 set, and with bit 16 set when flags bit 2 was set. It then writes the flags word with bit 31 cleared and the other bits kept.
- R6: For each completed frame, `st_txcp` and `st_txintr` each pulse for exactly one cycle.
- R7: A fetched flags word with bit 31 equal to 0 means software owns the descriptor. The engine then pulses `st_tdu`, writes nothing, halts, and leaves `cur_desc` at that descriptor's address.
- R8: A poll received while halted refetches the descriptor at `cur_desc`.
- R9: An error response to any memory access abandons the descriptor. The engine pulses `st_txberr`, performs no write-back, halts, and leaves `cur_desc` unchanged.
- R10: While a memory request or a byte waits for its handshake, its address, direction, data and last flag stay stable.
- R11: A length of zero sends no bytes, and the descriptor is still written back as complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| poll | input | 1 | One-cycle request to start or resume |
| list_base | input | AW | Start address of the descriptor list |
| cur_desc | output | AW | Current descriptor pointer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with acknowledge |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| st_txcp | output | 1 | Frame complete pulse |
| st_txintr | output | 1 | Transmit interrupt pulse |
| st_tdu | output | 1 | Descriptor unavailable pulse |
| st_txberr | output | 1 | Bus error pulse |

## Verification
The hardest case to reach is an error response that arrives after the descriptor has already been fetched in full, during the buffer read. That descriptor must stay hardware-owned, and the pointer must not advance. To reach it, the bench's memory model is told to return an error for one buffer address, and a valid owned descriptor that points at that address is linked after the halted one. The bench also resumes the chain from a halt by handing the stopping descriptor back to hardware and polling again. The memory latency varies from one access to the next, and the sink's ready signal follows a pseudo-random pattern, so handshake stalls fall on every byte lane.

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          poll,
  input  logic [AW-1:0] list_base,
  output logic [AW-1:0] cur_desc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          st_txcp,
  output logic          st_txintr,
  output logic          st_tdu,
  output logic          st_txberr
);

  localparam int OWN_BIT  = 31;
  localparam int IEN_BIT  = 2;
  localparam int DONE_BIT = 19;
  localparam int INT_BIT  = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_FLAGS, S_BUF, S_LEN, S_NEXT, S_DRD, S_STRM, S_WST, S_WFL
  } state_t;

  state_t        state;
  logic [AW-1:0] cur, bufa, nxt, waddr;
  logic [31:0]   flags, stlen, word;
  logic [1:0]    lane;
  logic [LW-1:0] remain;

  wire ok_ack  = mem_ack && !mem_err;
  wire bad_ack = mem_ack && mem_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '1;
      bufa   <= '0;
      nxt    <= '0;
      waddr  <= '0;
      flags  <= '0;
      stlen  <= '0;
      word   <= '0;
      lane   <= '0;
      remain <= '0;
    end else if (mem_req && bad_ack) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (tx_en && poll) begin
          if (&cur) cur <= list_base;
          state <= S_FLAGS;
        end
        S_FLAGS: if (ok_ack) begin
          flags <= mem_rdata;
          state <= mem_rdata[OWN_BIT] ? S_BUF : S_IDLE;
        end
        S_BUF: if (ok_ack) begin
          bufa  <= mem_rdata[AW-1:0];
          state <= S_LEN;
        end
        S_LEN: if (ok_ack) begin
          stlen  <= mem_rdata;
          remain <= mem_rdata[LW-1:0];
          state  <= S_NEXT;
        end
        S_NEXT: if (ok_ack) begin
          nxt   <= mem_rdata[AW-1:0];
          waddr <= {bufa[AW-1:2], 2'b00};
          lane  <= bufa[1:0];
          state <= (remain == '0) ? S_WST : S_DRD;
        end
        S_DRD: if (ok_ack) begin
          word  <= mem_rdata;
          state <= S_STRM;
        end
        S_STRM: if (tx_ready) begin
          remain <= remain - 1'b1;
          lane   <= lane + 2'd1;
          if (remain == LW'(1)) state <= S_WST;
          else if (lane == 2'd3) begin
            waddr <= waddr + AW'(4);
            state <= S_DRD;
          end
        end
        S_WST: if (ok_ack) state <= S_WFL;
        S_WFL: if (ok_ack) begin
          cur   <= nxt;
          state <= tx_en ? S_FLAGS : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cur_desc = cur;
  assign mem_req  = state inside {S_FLAGS, S_BUF, S_LEN, S_NEXT, S_DRD, S_WST, S_WFL};
  assign mem_we   = (state == S_WST) || (state == S_WFL);

  always_comb begin
    case (state)
      S_BUF:   mem_addr = cur + AW'(4);
      S_LEN:   mem_addr = cur + AW'(8);
      S_NEXT:  mem_addr = cur + AW'(12);
      S_DRD:   mem_addr = waddr;
      S_WST:   mem_addr = cur + AW'(8);
      default: mem_addr = cur;
    endcase
  end

  always_comb begin
    mem_wdata = '0;
    if (state == S_WST) begin
      mem_wdata = stlen;
      mem_wdata[DONE_BIT] = 1'b1;
      if (flags[IEN_BIT]) mem_wdata[INT_BIT] = 1'b1;
    end else if (state == S_WFL) begin
      mem_wdata = flags;
      mem_wdata[OWN_BIT] = 1'b0;
    end
  end

  assign tx_valid  = (state == S_STRM);
  assign tx_data   = word[{lane, 3'b000} +: 8];
  assign tx_last   = (state == S_STRM) && (remain == LW'(1));

  assign st_txcp   = (state == S_WFL) && ok_ack;
  assign st_txintr = st_txcp;
  assign st_tdu    = (state == S_FLAGS) && ok_ack && !mem_rdata[OWN_BIT];
  assign st_txberr = mem_req && bad_ack;

  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7
  tdu_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_tdu |=> !mem_req && !tx_valid && $stable(cur_desc));

  // R9
  berr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_txberr |=> !mem_req && !tx_valid && $stable(cur_desc));

  // R6
  done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_txcp |-> mem_we && mem_ack && !mem_wdata[OWN_BIT]);

  // R4
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);

  // R6
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_txcp, st_tdu, st_txberr}));

endmodule

// File: tb/txring_dma_tb.sv
module txring_dma_tb;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0, tx_en = 0, poll = 0;
  logic [31:0] list_base = 32'h100;
  logic [31:0] cur_desc, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic        tx_valid, tx_ready = 0, tx_last;
  logic [7:0]  tx_data;
  logic        st_txcp, st_txintr, st_tdu, st_txberr;

  txring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .poll(poll), .list_base(list_base),
    .cur_desc(cur_desc), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .st_txcp(st_txcp), .st_txintr(st_txintr), .st_tdu(st_tdu), .st_txberr(st_txberr)
  );

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0, checks = 0;
  logic [31:0] mem [512];
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  logic [31:0] wlog [$];
  logic [31:0] first_rd;
  logic        want_first = 0;
  logic [8:0]  expq [$];
  int wcnt = 0, lat = 0;
  int n_cp = 0, n_intr = 0, n_tdu = 0, n_berr = 0, n_req = 0;
  logic [7:0] lfsr = 8'hB5;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return (a[7:0] ^ {5'b0, a[10:8]}) + 8'h11;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder with varying latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= '0; wcnt <= 0; lat <= 0;
    end else begin
      mem_ack <= 0; mem_err <= 0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          mem_ack <= 1; wcnt <= 0; lat <= (lat == 2) ? 0 : lat + 1;
          if (want_first) begin first_rd <= mem_addr; want_first <= 0; end
          if (mem_addr == err_addr) mem_err <= 1;
          else if (mem_we) begin
            mem[mem_addr[10:2]] <= mem_wdata;
            wlog.push_back(mem_addr);
          end else mem_rdata <= mem[mem_addr[10:2]];
        end else wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = lfsr[0] | lfsr[3];
  end

  // monitor: scoreboard pop and event counts
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) n_req++;
      if (st_txcp) n_cp++;
      if (st_txintr) n_intr++;
      if (st_tdu) n_tdu++;
      if (st_txberr) n_berr++;
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) check(0, "R4 unexpected byte", {23'b0, tx_last, tx_data}, 32'h0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({tx_last, tx_data} == e, "R4 byte/last", {23'b0, tx_last, tx_data}, {23'b0, e});
        end
      end
    end
  end

  task automatic put_desc(input logic [31:0] d, input logic [31:0] fl, input logic [31:0] b,
                          input logic [31:0] sl, input logic [31:0] nx);
    mem[d[10:2]] = fl; mem[d[10:2]+1] = b; mem[d[10:2]+2] = sl; mem[d[10:2]+3] = nx;
  endtask

  task automatic expect_frame(input logic [31:0] b, input int len);
    for (int i = 0; i < len; i++) expq.push_back({(i == len-1), pat(b + i)});
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  task automatic wait_count(ref int cnt, input int target);
    for (int i = 0; i < 5000 && cnt < target; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS*100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r;
    for (int i = 0; i < 512; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    repeat (3) @(negedge clk);
    // R1
    check(!tx_valid && !mem_req, "R1 idle outputs", {30'b0, tx_valid, mem_req}, 32'h0);
    check(cur_desc == 32'hFFFF_FFFF, "R1 pointer invalid", cur_desc, 32'hFFFF_FFFF);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: poll without enable is ignored
    do_poll();
    repeat (20) @(negedge clk);
    check(n_req == 0, "R2 no request when disabled", n_req, 0);
    check(cur_desc == 32'hFFFF_FFFF, "R2 pointer untouched", cur_desc, 32'hFFFF_FFFF);

    // chain: unaligned frame with irq, aligned frame, empty frame, software-owned stop
    put_desc(32'h100, 32'h8000_0004, 32'h403, 32'd7, 32'h110);
    put_desc(32'h110, 32'h8000_0000, 32'h500, 32'd5, 32'h120);
    put_desc(32'h120, 32'h8000_0000, 32'h580, 32'd0, 32'h130);
    put_desc(32'h130, 32'h0000_0000, 32'h602, 32'd3, 32'h140);
    put_desc(32'h140, 32'h0000_0000, 32'h700, 32'd4, 32'h150);
    expect_frame(32'h403, 7);
    expect_frame(32'h500, 5);
    tx_en = 1; want_first = 1;
    do_poll();
    wait_count(n_tdu, 1);
    // R3
    check(first_rd == 32'h100, "R3 starts at list base", first_rd, 32'h100);
    // R4
    check(expq.size() == 0, "R4 all bytes sent", expq.size(), 0);
    // R5
    check(mem[32'h108 >> 2] == 32'h0009_0007, "R5 status with irq", mem[32'h108 >> 2], 32'h0009_0007);
    check(mem[32'h100 >> 2] == 32'h0000_0004, "R5 flags owner cleared", mem[32'h100 >> 2], 32'h4);
    check(mem[32'h118 >> 2] == 32'h0008_0005, "R5 status no irq", mem[32'h118 >> 2], 32'h0008_0005);
    check(mem[32'h110 >> 2] == 32'h0, "R5 flags second", mem[32'h110 >> 2], 32'h0);
    // R11
    check(mem[32'h128 >> 2] == 32'h0008_0000, "R11 empty frame completed", mem[32'h128 >> 2], 32'h0008_0000);
    r = (wlog.size() == 6) && wlog[0] == 32'h108 && wlog[1] == 32'h100 && wlog[2] == 32'h118 &&
        wlog[3] == 32'h110 && wlog[4] == 32'h128 && wlog[5] == 32'h120;
    check(r != 0, "R5 status before flags", wlog.size(), 6);
    // R6
    check(n_cp == 3 && n_intr == 3, "R6 pulses per frame", {n_cp[15:0], n_intr[15:0]}, 32'h0003_0003);
    // R7
    check(n_tdu == 1, "R7 unavailable pulse", n_tdu, 1);
    check(cur_desc == 32'h130, "R7 pointer at stop", cur_desc, 32'h130);
    check(mem[32'h130 >> 2] == 32'h0 && mem[32'h138 >> 2] == 32'd3, "R7 no write-back",
          mem[32'h138 >> 2], 32'd3);

    // R8: hand back the stopping descriptor and poll again
    mem[32'h130 >> 2] = 32'h8000_0000;
    expect_frame(32'h602, 3);
    do_poll();
    wait_count(n_tdu, 2);
    check(expq.size() == 0, "R8 resumed frame sent", expq.size(), 0);
    check(cur_desc == 32'h140, "R8 pointer advanced", cur_desc, 32'h140);
    check(mem[32'h138 >> 2] == 32'h0008_0003, "R8 resumed status", mem[32'h138 >> 2], 32'h0008_0003);
    check(n_cp == 4, "R8 one more completion", n_cp, 4);

    // R9: error on buffer read after full descriptor fetch
    mem[32'h140 >> 2] = 32'h8000_0004;
    err_addr = 32'h700;
    do_poll();
    wait_count(n_berr, 1);
    check(n_berr == 1, "R9 bus error pulse", n_berr, 1);
    r = n_req;
    repeat (20) @(negedge clk);
    check(n_req == r, "R9 halted after error", n_req, r);
    check(cur_desc == 32'h140, "R9 pointer kept", cur_desc, 32'h140);
    check(mem[32'h140 >> 2] == 32'h8000_0004, "R9 still hardware owned", mem[32'h140 >> 2], 32'h8000_0004);
    check(mem[32'h148 >> 2] == 32'd4, "R9 status untouched", mem[32'h148 >> 2], 32'd4);
    check(n_cp == 4, "R9 no completion", n_cp, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule